// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer with Coherent Count Capture

This block holds four programmable down-counting timers behind a simple synchronous register bus. Each timer has a run bit, an interrupt-enable bit and a sticky status bit. The status bit records that the timer wrapped through zero while interrupts were enabled. All enabled status bits share one registered interrupt line. Software can clear a status bit in two ways: it can write 0 to that bit in the control register, or it can write any value to the timer's own clear register.

Timers 1 and 2 are 16 bits wide and share one packed load register. Timers 3 and 4 are 32 bits wide and each has its own load and count register. A capture-mode bit sets how counts are read. In mode 0, every count read returns the count at the moment of that read. In mode 1, a read of the packed timer 1/2 count register also freezes timers 3 and 4. Later reads of their count registers then return the frozen values, so software gets all four counts from one instant.

Top module: `snaptmr_top`

## Requirements
- R1: After reset every register reads 0, all timers are stopped, and `irq_o` is 0.
- R2: Control register 0x00 bit i (i = 0..3) is the run bit of timer i+1. A timer whose run bit is 0 holds its count.
- R3: A running timer whose count is nonzero decrements by one each clock. At zero it reloads from its load register on the next clock, which gives a period of load+1 cycles.
- R4: When a running timer is at zero and its interrupt enable (control bit 4+i) is 1, its status bit (control bit 8+i) is set. No status is set while the enable is 0.
- R5: A write to control register 0x00 clears every status bit whose written data bit 8+i is 0. A 1 written there has no effect. Control bits other than 0..11 read 0.
- R6: Any write to the clear register of timer i+1, at address 0x24+4*i, clears that timer's status bit. Reads of these addresses return 0.
- R7: When a status set and a clear of the same bit fall in one cycle, the bit ends up set.
- R8: `irq_o` equals the registered OR over all timers of (status AND interrupt enable). It falls in the cycle after the last such term goes to 0.
- R9: Register 0x04 is a full 32-bit read/write register. Bit 0 selects the capture mode.
- R10: In mode 0, a read of 0x08 returns timer 1 in bits [15:0] and timer 2 in bits [31:16]. A read of 0x1C or 0x20 returns the live count of timer 3 or timer 4 at that read.
- R11: In mode 1, a read of 0x08 freezes the counts of timers 3 and 4. Reads of 0x1C and 0x20 then return the frozen values and do not refreeze.
- R12: Load registers are 0x10 (timer 1 in [15:0], timer 2 in [31:16]), 0x14 (timer 3) and 0x18 (timer 4). Each reads back what was written.
- R13: Read data appears on `bus_rdata` in the cycle after `bus_rd`, and holds until the next read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach is a clear that arrives in the same cycle as a status set. Setting this up by timing a write against a long countdown is fragile. The stimulus loads timer 1 with 0 and enables it, so the timer wraps on every clock, and then issues both kinds of clear. The frozen snapshot is reached with large loads on timers 3 and 4. A freeze read is followed by idle cycles, so the live counts have visibly moved on before the frozen values are read back. A few thousand random register operations with small loads then mix wraps, clears, mode changes and reads.

// File: rtl/snaptmr_pkg.sv
package snaptmr_pkg;
   localparam int NCH = 4;
   localparam logic [7:0] A_CTRL  = 8'h00;
   localparam logic [7:0] A_MODE  = 8'h04;
   localparam logic [7:0] A_CNT12 = 8'h08;
   localparam logic [7:0] A_LD12  = 8'h10;
   localparam logic [7:0] A_LD3   = 8'h14;
   localparam logic [7:0] A_LD4   = 8'h18;
   localparam logic [7:0] A_CNT3  = 8'h1C;
   localparam logic [7:0] A_CNT4  = 8'h20;
   localparam logic [7:0] A_CLR0  = 8'h24;

   function automatic logic [7:0] clr_addr(input int ch);
      return A_CLR0 + 8'(4 * ch);
   endfunction
endpackage

// File: rtl/snaptmr_chan.sv
module snaptmr_chan #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic [W-1:0] load_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (run_i)
         cnt_q <= (cnt_q == '0) ? load_i : cnt_q - 1'b1;
   end

   assign cnt_o  = cnt_q;
   assign wrap_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/snaptmr_irq.sv
module snaptmr_irq #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] wrap_i,
   input  logic [N-1:0] ie_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] stat_o,
   output logic         irq_o
);
   logic [N-1:0] stat_q;
   logic         irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         stat_q <= (stat_q & ~clr_i) | (wrap_i & ie_i);
         irq_q  <= |(stat_q & ie_i);
      end
   end

   assign stat_o = stat_q;
   assign irq_o  = irq_q;
endmodule

// File: rtl/snaptmr_latch.sv
module snaptmr_latch #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          snap_i,
   input  logic          rd12_i,
   input  logic          rd3_i,
   input  logic          rd4_i,
   input  logic [DW-1:0] cnt3_i,
   input  logic [DW-1:0] cnt4_i,
   output logic [DW-1:0] lat3_o,
   output logic [DW-1:0] lat4_o
);
   logic [DW-1:0] lat3_q, lat4_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat3_q <= '0;
         lat4_q <= '0;
      end else begin
         if ((snap_i && rd12_i) || (!snap_i && rd3_i)) lat3_q <= cnt3_i;
         if ((snap_i && rd12_i) || (!snap_i && rd4_i)) lat4_q <= cnt4_i;
      end
   end

   assign lat3_o = lat3_q;
   assign lat4_o = lat4_q;
endmodule

// File: rtl/snaptmr_top.sv
module snaptmr_top #(
   parameter int AW  = 8,
   parameter int DW  = 32,
   parameter int W12 = 16,
   parameter int W34 = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          irq_o
);
   import snaptmr_pkg::*;

   localparam int HALF = DW / 2;

   if (W12 > HALF) begin : g_bad_w12
      $error("W12 must fit in half the data width");
   end
   if (W34 > DW || W34 < 2) begin : g_bad_w34
      $error("W34 must be between 2 and DW");
   end
   if (AW < 6 || DW < 12) begin : g_bad_bus
      $error("bus too narrow for the register map");
   end

   logic [NCH-1:0]         run_q, ie_q, stat_w, wrap_w, clr_w;
   logic [NCH-1:0][DW-1:0] ld_q, cnt_w;
   logic [DW-1:0]          mode_q, lat3_w, lat4_w, ctrl_rd;
   logic                   snap;

   logic wr_ctrl, wr_mode, wr_ld12, wr_ld3, wr_ld4;
   logic rd12, rd3, rd4;

   assign wr_ctrl = bus_wr && (bus_addr == AW'(A_CTRL));
   assign wr_mode = bus_wr && (bus_addr == AW'(A_MODE));
   assign wr_ld12 = bus_wr && (bus_addr == AW'(A_LD12));
   assign wr_ld3  = bus_wr && (bus_addr == AW'(A_LD3));
   assign wr_ld4  = bus_wr && (bus_addr == AW'(A_LD4));
   assign rd12    = bus_rd && (bus_addr == AW'(A_CNT12));
   assign rd3     = bus_rd && (bus_addr == AW'(A_CNT3));
   assign rd4     = bus_rd && (bus_addr == AW'(A_CNT4));
   assign snap    = mode_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= '0;
         ie_q   <= '0;
         mode_q <= '0;
         ld_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q <= bus_wdata[NCH-1:0];
            ie_q  <= bus_wdata[2*NCH-1:NCH];
         end
         if (wr_mode) mode_q <= bus_wdata;
         if (wr_ld12) begin
            ld_q[0] <= DW'(bus_wdata[W12-1:0]);
            ld_q[1] <= DW'(bus_wdata[HALF +: W12]);
         end
         if (wr_ld3) ld_q[2] <= DW'(bus_wdata[W34-1:0]);
         if (wr_ld4) ld_q[3] <= DW'(bus_wdata[W34-1:0]);
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int CW = (c < 2) ? W12 : W34;
      logic [CW-1:0] cnt_c;

      snaptmr_chan #(.W(CW)) chan_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .run_i  (run_q[c]),
         .load_i (ld_q[c][CW-1:0]),
         .cnt_o  (cnt_c),
         .wrap_o (wrap_w[c])
      );

      assign cnt_w[c] = DW'(cnt_c);
      assign clr_w[c] = (wr_ctrl && !bus_wdata[2*NCH + c])
                      || (bus_wr && (bus_addr == AW'(clr_addr(c))));
   end

   snaptmr_irq #(.N(NCH)) irq_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrap_i (wrap_w),
      .ie_i   (ie_q),
      .clr_i  (clr_w),
      .stat_o (stat_w),
      .irq_o  (irq_o)
   );

   snaptmr_latch #(.DW(DW)) latch_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .snap_i (snap),
      .rd12_i (rd12),
      .rd3_i  (rd3),
      .rd4_i  (rd4),
      .cnt3_i (cnt_w[2]),
      .cnt4_i (cnt_w[3]),
      .lat3_o (lat3_w),
      .lat4_o (lat4_w)
   );

   always_comb begin
      ctrl_rd = '0;
      ctrl_rd[NCH-1:0]         = run_q;
      ctrl_rd[2*NCH-1:NCH]     = ie_q;
      ctrl_rd[3*NCH-1:2*NCH]   = stat_w;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_rd) begin
         case (bus_addr)
            AW'(A_CTRL):  bus_rdata <= ctrl_rd;
            AW'(A_MODE):  bus_rdata <= mode_q;
            AW'(A_CNT12): bus_rdata <= cnt_w[0] | (cnt_w[1] << HALF);
            AW'(A_LD12):  bus_rdata <= ld_q[0] | (ld_q[1] << HALF);
            AW'(A_LD3):   bus_rdata <= ld_q[2];
            AW'(A_LD4):   bus_rdata <= ld_q[3];
            AW'(A_CNT3):  bus_rdata <= snap ? lat3_w : cnt_w[2];
            AW'(A_CNT4):  bus_rdata <= snap ? lat4_w : cnt_w[3];
            default:      bus_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/snaptmr_chk.sv
module snaptmr_chk #(
   parameter int AW = 8,
   parameter int DW = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_wr,
   input logic                 bus_rd,
   input logic [AW-1:0]        bus_addr,
   input logic [3:0]           run_q,
   input logic [3:0]           ie_q,
   input logic [3:0]           stat_w,
   input logic [3:0][DW-1:0]   cnt_w,
   input logic [DW-1:0]        lat3_w,
   input logic                 snap,
   input logic                 irq_o
);
   import snaptmr_pkg::*;

   for (genvar c = 0; c < 4; c++) begin : g_p
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !run_q[c] |=> $stable(cnt_w[c]));

      assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (run_q[c] && cnt_w[c] != '0) |=> (cnt_w[c] == $past(cnt_w[c]) - 1'b1));

      assert_setsrc_R4: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_w[c]) |-> $past(run_q[c] && ie_q[c] && cnt_w[c] == '0));

      assert_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == AW'(clr_addr(c))
          && !(run_q[c] && ie_q[c] && cnt_w[c] == '0)) |=> !stat_w[c]);

      assert_setwins_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (run_q[c] && ie_q[c] && cnt_w[c] == '0) |=> stat_w[c]);
   end

   assert_irqsrc_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(|(stat_w & ie_q)));

   assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == AW'(A_CNT3) && snap) |=> $stable(lat3_w));
endmodule

bind snaptmr_top snaptmr_chk #(.AW(AW), .DW(DW)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_wr   (bus_wr),
   .bus_rd   (bus_rd),
   .bus_addr (bus_addr),
   .run_q    (run_q),
   .ie_q     (ie_q),
   .stat_w   (stat_w),
   .cnt_w    (cnt_w),
   .lat3_w   (lat3_w),
   .snap     (snap),
   .irq_o    (irq_o)
);

// File: tb/snaptmr_top_tb.sv
`timescale 1ns/1ps
module snaptmr_top_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   snaptmr_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   // reference model state
   logic [31:0] m_cnt [4];
   logic [31:0] m_ld [4];
   logic [3:0]  m_run, m_ie, m_stat;
   logic [31:0] m_mode, m_lat3, m_lat4, m_rd;
   logic        m_irq;

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         8'h00: return {20'd0, m_stat, m_ie, m_run};
         8'h04: return m_mode;
         8'h08: return {m_cnt[1][15:0], m_cnt[0][15:0]};
         8'h10: return {m_ld[1][15:0], m_ld[0][15:0]};
         8'h14: return m_ld[2];
         8'h18: return m_ld[3];
         8'h1C: return m_mode[0] ? m_lat3 : m_cnt[2];
         8'h20: return m_mode[0] ? m_lat4 : m_cnt[3];
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk) begin : model
      logic [3:0] wrap, clr;
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_ld[i] = 0; end
         m_run = 0; m_ie = 0; m_stat = 0; m_mode = 0;
         m_lat3 = 0; m_lat4 = 0; m_rd = 0; m_irq = 0;
      end else begin
         for (int i = 0; i < 4; i++) begin
            wrap[i] = m_run[i] && (m_cnt[i] == 0);
            clr[i]  = (bus_wr && bus_addr == 8'h00 && !bus_wdata[8+i])
                    || (bus_wr && bus_addr == 8'(8'h24 + 4*i));
         end
         m_irq = |(m_stat & m_ie);
         if (bus_rd) begin
            m_rd = exp_read(bus_addr);
            if (m_mode[0] && bus_addr == 8'h08) begin
               m_lat3 = m_cnt[2]; m_lat4 = m_cnt[3];
            end
            if (!m_mode[0] && bus_addr == 8'h1C) m_lat3 = m_cnt[2];
            if (!m_mode[0] && bus_addr == 8'h20) m_lat4 = m_cnt[3];
         end
         for (int i = 0; i < 4; i++)
            if (m_run[i]) m_cnt[i] = wrap[i] ? m_ld[i] : m_cnt[i] - 1;
         m_stat = (m_stat & ~clr) | (wrap & m_ie);
         if (bus_wr) begin
            case (bus_addr)
               8'h00: begin m_run = bus_wdata[3:0]; m_ie = bus_wdata[7:4]; end
               8'h04: m_mode = bus_wdata;
               8'h10: begin m_ld[0] = {16'd0, bus_wdata[15:0]};
                            m_ld[1] = {16'd0, bus_wdata[31:16]}; end
               8'h14: m_ld[2] = bus_wdata;
               8'h18: m_ld[3] = bus_wdata;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic op(input bit w, input bit r, input logic [7:0] a,
                     input logic [31:0] d, input string tag);
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      chk("R8 irq", {31'd0, irq_o}, {31'd0, m_irq});
      if (r) chk(tag, bus_rdata, m_rd);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) op(1'b0, 1'b0, 8'h00, 32'd0, "idle");
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL R13 watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] addrs [14];
      addrs = '{8'h00, 8'h04, 8'h08, 8'h10, 8'h14, 8'h18, 8'h1C,
                8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h0C, 8'h34};
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values on every address
      chk("R1 irq", {31'd0, irq_o}, 32'd0);
      for (int i = 0; i < 14; i++) op(1'b0, 1'b1, addrs[i], 0, "R1 reset read");

      // R7: timer 1 with load 0 wraps every cycle, clears must lose
      op(1'b1, 1'b0, 8'h10, 32'h0000_0000, "R12");
      op(1'b1, 1'b0, 8'h00, 32'h0000_0011, "R2");
      idle(2);
      op(1'b0, 1'b1, 8'h00, 0, "R4 status set");
      op(1'b1, 1'b0, 8'h24, 32'hFFFF_FFFF, "R7");
      op(1'b0, 1'b1, 8'h00, 0, "R7 set wins over clear register");
      op(1'b1, 1'b0, 8'h00, 32'h0000_0010, "R7");
      op(1'b0, 1'b1, 8'h00, 0, "R7 set wins over write-0");
      // timer now stopped: clear register takes effect, irq drops
      op(1'b1, 1'b0, 8'h24, 32'd0, "R6");
      op(1'b0, 1'b1, 8'h00, 0, "R6 clear register");
      op(1'b0, 1'b1, 8'h24, 0, "R6 clear reads 0");

      // R5: writing 1 to status leaves it, writing 0 clears
      op(1'b1, 1'b0, 8'h10, 32'h0003_0002, "R12");
      op(1'b0, 1'b1, 8'h10, 0, "R12 load readback");
      op(1'b1, 1'b0, 8'h00, 32'h0000_0022, "R2");
      idle(6);
      op(1'b1, 1'b0, 8'h00, 32'h0000_0F20, "R5");
      op(1'b0, 1'b1, 8'h00, 0, "R5 write 1 no effect");
      op(1'b1, 1'b0, 8'h00, 32'hFFFF_F000, "R5");
      op(1'b0, 1'b1, 8'h00, 0, "R5 write 0 clears, upper bits 0");
      op(1'b0, 1'b1, 8'h08, 0, "R2 stopped timers hold");

      // R9 / R11 / R10: capture modes
      op(1'b1, 1'b0, 8'h04, 32'hA5A5_A5A5, "R9");
      op(1'b0, 1'b1, 8'h04, 0, "R9 mode readback");
      op(1'b1, 1'b0, 8'h14, 32'd200, "R12");
      op(1'b1, 1'b0, 8'h18, 32'd300, "R12");
      op(1'b1, 1'b0, 8'h00, 32'h0000_000F, "R3");
      idle(3);
      op(1'b0, 1'b1, 8'h08, 0, "R11 freeze read");
      idle(5);
      op(1'b0, 1'b1, 8'h1C, 0, "R11 timer3 frozen");
      op(1'b0, 1'b1, 8'h20, 0, "R11 timer4 frozen");
      op(1'b0, 1'b1, 8'h1C, 0, "R11 no refreeze");
      op(1'b1, 1'b0, 8'h04, 32'h0000_0000, "R9");
      op(1'b0, 1'b1, 8'h1C, 0, "R10 timer3 live");
      op(1'b0, 1'b1, 8'h20, 0, "R10 timer4 live");
      op(1'b0, 1'b1, 8'h08, 0, "R10 packed 1/2 count");
      op(1'b0, 1'b1, 8'h34, 0, "R13 unmapped");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [7:0]  a;
         logic [31:0] d;
         int          kind;
         a    = addrs[$urandom_range(0, 13)];
         kind = $urandom_range(0, 9);
         d    = $urandom();
         if (a == 8'h10) d = d & 32'h000F_000F;
         if (a == 8'h14 || a == 8'h18) d = d & 32'h0000_001F;
         if (a == 8'h04) d = d & 32'hFFFF_FF01;
         if (kind < 4)      op(1'b1, 1'b0, a, d, "R3 random write");
         else if (kind < 8) op(1'b0, 1'b1, a, 0, "R3 random read");
         else               idle(1);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule